// File: doc/BRIEF.md
# Mixed-Format Fixed-Point Three-Operand Adder

This block sums three 5-bit fixed-point operands whose binary points and signedness differ, and it returns one exact two's complement word. Operand `x` is signed with one integer bit (the sign) and four fraction bits. Operand `y` is signed with two integer bits and three fraction bits. Operand `z` is an unsigned integer with no fraction bits. The result is 11 bits wide, and its four least significant bits are fraction bits, so one result LSB weighs 1/16.

Each operand first goes to an aligner. The aligner shifts it to four fraction bits and sign-extends or zero-extends it to the result width. A row of full adders then reduces the three aligned words to a sum word and a carry word. The carry word is moved up one place, and a ripple carry-propagate stage adds the two words. The exact sum always lies between -3.0 and 33.8125, so the result cannot overflow, and any carry out of the top bit is discarded. A parameter selects one of two output variants: a single output register that loads on the input strobe, or a purely combinational output.

Top module: `fxadd3`

## Requirements
- R1: With `y` and `z` at zero, the result equals `x` read as a signed 5-bit value with four fraction bits, sign-extended to 11 bits, with its bit positions unchanged.
- R2: With `x` and `z` at zero, the result equals `y` read as a signed value, shifted left by one position with a zero fill, and sign-extended to 11 bits.
- R3: With `x` and `y` at zero, the result equals `z` read as an unsigned value, shifted left by four positions and zero-extended to 11 bits.
- R4: For any inputs, `$signed(result)` equals `$signed(x) + 2*$signed(y) + 16*z` as an 11-bit two's complement word. `result[3:0]` holds the fraction.
- R5: The range ends are exact and do not wrap. `x=10000`, `y=10000`, `z=00000` gives `11111010000` (-3.0). `x=01111`, `y=01111`, `z=11111` gives `01000011101` (33.8125).
- R6: With the output register enabled (`REG_OUT=1`), `result` and `out_valid` appear on the first rising clock edge after the cycle in which `in_valid` was high. `out_valid` is high for exactly that one cycle.
- R7: With the output register enabled, `result` holds its last value through any cycle in which `in_valid` is low, while `x`, `y` and `z` keep changing.
- R8: Reset is synchronous and active-high. A clock edge with `rst` high sets `out_valid` to 0 and `result` to 0 in the registered variant.
- R9: With `REG_OUT=0`, `result` follows the inputs in the same cycle, and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking `x`, `y` and `z` as valid |
| x | input | 5 | Signed operand, 1 integer bit and 4 fraction bits |
| y | input | 5 | Signed operand, 2 integer bits and 3 fraction bits |
| z | input | 5 | Unsigned operand, 5 integer bits |
| result | output | 11 | Two's complement sum, 7 integer bits and 4 fraction bits |
| out_valid | output | 1 | Strobe marking `result` as valid |

## Verification
In the registered variant, the result for a strobe at one edge is due at the next rising edge. The combinational variant's result is due in the same cycle. The bench drives inputs on the falling edge. It checks the combinational instance 1 ns later, then checks the registered instance 1 ns after the following rising edge. The reference model keeps the last strobed sum and compares against it, so idle cycles test that the registered result holds. The bench sweeps every input combination and adds directed cases for each operand on its own, for the range ends and for a reset applied during traffic.

// File: rtl/fxadd_pkg.sv
package fxadd_pkg;

    // Operand and result geometry
    parameter int OPD_W    = 5;
    parameter int SUM_W    = 11;
    parameter int SUM_FRAC = 4;

    // Per-operand format
    parameter int X_FRAC = 4;
    parameter int Y_FRAC = 3;
    parameter int Z_FRAC = 0;

    typedef enum logic {
        EXT_ZERO = 1'b0,
        EXT_SIGN = 1'b1
    } ext_mode_e;

    typedef logic [SUM_W-1:0] sum_word_t;

    // Output of the 3:2 reduction; carry already weighted into place
    typedef struct packed {
        sum_word_t part_sum;
        sum_word_t part_carry;
    } csa_pair_t;

    // Output record carried through the optional register
    typedef struct packed {
        logic      valid;
        sum_word_t value;
    } sum_rec_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic par3(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

endpackage

// File: rtl/fxadd_fa.sv
module fxadd_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    import fxadd_pkg::*;

    always_comb begin
        s  = par3(a, b, ci);
        co = maj3(a, b, ci);
    end
endmodule

// File: rtl/fxadd_align.sv
module fxadd_align #(
    parameter int                   IN_W     = 5,
    parameter int                   IN_FRAC  = 4,
    parameter fxadd_pkg::ext_mode_e EXT      = fxadd_pkg::EXT_SIGN,
    parameter int                   OUT_W    = 11,
    parameter int                   OUT_FRAC = 4
) (
    input  logic [IN_W-1:0]  opd,
    output logic [OUT_W-1:0] aligned
);
    import fxadd_pkg::*;

    localparam int SHIFT = OUT_FRAC - IN_FRAC;

    // Fill for bits above the operand's top bit
    logic fill_bit;

    generate
        if (EXT == EXT_SIGN) begin : g_sign
            assign fill_bit = opd[IN_W-1];
        end else begin : g_zero
            assign fill_bit = 1'b0;
        end
    endgenerate

    generate
        for (genvar i = 0; i < OUT_W; i++) begin : g_bit
            if (i < SHIFT) begin : g_low
                assign aligned[i] = 1'b0;
            end else if (i - SHIFT < IN_W) begin : g_mid
                assign aligned[i] = opd[i-SHIFT];
            end else begin : g_high
                assign aligned[i] = fill_bit;
            end
        end
    endgenerate
endmodule

// File: rtl/fxadd_csa.sv
module fxadd_csa #(
    parameter int W = 11
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] part_sum,
    output logic [W-1:0] part_carry
);
    // part_carry is already shifted up one place; the top carry is dropped
    assign part_carry[0] = 1'b0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_col
            if (i < W - 1) begin : g_full
                fxadd_fa u_fa (
                    .a  (a[i]),
                    .b  (b[i]),
                    .ci (c[i]),
                    .s  (part_sum[i]),
                    .co (part_carry[i+1])
                );
            end else begin : g_top
                assign part_sum[i] = a[i] ^ b[i] ^ c[i];
            end
        end
    endgenerate
endmodule

// File: rtl/fxadd_cpa.sv
module fxadd_cpa #(
    parameter int W = 11
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] total
);
    logic [W-1:0] chain;

    assign chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_rip
            if (i < W - 1) begin : g_full
                fxadd_fa u_fa (
                    .a  (a[i]),
                    .b  (b[i]),
                    .ci (chain[i]),
                    .s  (total[i]),
                    .co (chain[i+1])
                );
            end else begin : g_top
                // Carry out of the top bit is discarded
                assign total[i] = a[i] ^ b[i] ^ chain[i];
            end
        end
    endgenerate
endmodule

// File: rtl/fxadd3.sv
module fxadd3 #(
    parameter int OPD_W    = fxadd_pkg::OPD_W,
    parameter int SUM_W    = fxadd_pkg::SUM_W,
    parameter int SUM_FRAC = fxadd_pkg::SUM_FRAC,
    parameter int X_FRAC   = fxadd_pkg::X_FRAC,
    parameter int Y_FRAC   = fxadd_pkg::Y_FRAC,
    parameter int Z_FRAC   = fxadd_pkg::Z_FRAC,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OPD_W-1:0] x,
    input  logic [OPD_W-1:0] y,
    input  logic [OPD_W-1:0] z,
    output logic [SUM_W-1:0] result,
    output logic             out_valid
);
    import fxadd_pkg::*;

    logic [SUM_W-1:0] x_al, y_al, z_al;
    logic [SUM_W-1:0] total;
    csa_pair_t        red;
    sum_rec_t         nxt_rec;

    fxadd_align #(
        .IN_W(OPD_W), .IN_FRAC(X_FRAC), .EXT(EXT_SIGN),
        .OUT_W(SUM_W), .OUT_FRAC(SUM_FRAC)
    ) u_align_x (.opd(x), .aligned(x_al));

    fxadd_align #(
        .IN_W(OPD_W), .IN_FRAC(Y_FRAC), .EXT(EXT_SIGN),
        .OUT_W(SUM_W), .OUT_FRAC(SUM_FRAC)
    ) u_align_y (.opd(y), .aligned(y_al));

    fxadd_align #(
        .IN_W(OPD_W), .IN_FRAC(Z_FRAC), .EXT(EXT_ZERO),
        .OUT_W(SUM_W), .OUT_FRAC(SUM_FRAC)
    ) u_align_z (.opd(z), .aligned(z_al));

    fxadd_csa #(.W(SUM_W)) u_csa (
        .a          (x_al),
        .b          (y_al),
        .c          (z_al),
        .part_sum   (red.part_sum),
        .part_carry (red.part_carry)
    );

    fxadd_cpa #(.W(SUM_W)) u_cpa (
        .a     (red.part_sum),
        .b     (red.part_carry),
        .total (total)
    );

    assign nxt_rec.valid = in_valid;
    assign nxt_rec.value = total;

    generate
        if (REG_OUT) begin : g_reg
            sum_rec_t out_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    out_q <= '0;
                end else begin
                    out_q.valid <= nxt_rec.valid;
                    if (nxt_rec.valid) begin
                        out_q.value <= nxt_rec.value;
                    end
                end
            end

            assign result    = out_q.value;
            assign out_valid = out_q.valid;
        end else begin : g_comb
            assign result    = nxt_rec.value;
            assign out_valid = nxt_rec.valid;
        end
    endgenerate
endmodule

// File: rtl/fxadd3_chk.sv
module fxadd3_chk #(
    parameter int OPD_W   = 5,
    parameter int SUM_W   = 11,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OPD_W-1:0] x,
    input logic [OPD_W-1:0] y,
    input logic [OPD_W-1:0] z,
    input logic [SUM_W-1:0] result,
    input logic             out_valid
);
    int  want;
    logic seen;

    always_comb begin
        want = int'($signed(x)) + 2 * int'($signed(y)) + 16 * int'(z);
    end

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    // R5
    range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'($signed(result)) >= -48 && int'($signed(result)) <= 541))
        else $error("range_chk");

    generate
        if (REG_OUT) begin : g_reg
            // R8
            reset_clear_chk: assert property (@(posedge clk)
                rst |=> (!out_valid && result == '0))
                else $error("reset_clear_chk");

            // R6
            valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
                seen |-> (out_valid == $past(in_valid)))
                else $error("valid_latency_chk");

            // R4
            exact_sum_chk: assert property (@(posedge clk) disable iff (rst)
                (seen && $past(in_valid)) |-> (int'($signed(result)) == $past(want)))
                else $error("exact_sum_chk");

            // R7
            hold_chk: assert property (@(posedge clk) disable iff (rst)
                (seen && !$past(in_valid)) |-> $stable(result))
                else $error("hold_chk");
        end else begin : g_comb
            // R9
            comb_sum_chk: assert property (@(posedge clk) disable iff (rst)
                in_valid |-> (int'($signed(result)) == want))
                else $error("comb_sum_chk");

            // R9
            comb_valid_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid == in_valid)
                else $error("comb_valid_chk");
        end
    endgenerate
endmodule

bind fxadd3 fxadd3_chk #(
    .OPD_W   (OPD_W),
    .SUM_W   (SUM_W),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .x         (x),
    .y         (y),
    .z         (z),
    .result    (result),
    .out_valid (out_valid)
);

// File: tb/fxadd3_bench.sv
`timescale 1ns/1ps
module fxadd3_bench;
    localparam int HALF = 10;  // 50 MHz

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  x = '0, y = '0, z = '0;
    logic [10:0] r_res, c_res;
    logic        r_vld, c_vld;

    int n_run  = 0;
    int n_fail = 0;
    int held   = 0;
    bit done   = 1'b0;

    always #HALF clk = ~clk;

    fxadd3 #(.REG_OUT(1'b1)) u_fxadd3 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x(x), .y(y), .z(z),
        .result(r_res), .out_valid(r_vld)
    );

    fxadd3 #(.REG_OUT(1'b0)) u_fxadd3_comb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x(x), .y(y), .z(z),
        .result(c_res), .out_valid(c_vld)
    );

    function automatic int model(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c);
        return int'($signed(a)) + 2 * int'($signed(b)) + 16 * int'(c);
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Drive at the falling edge, check comb 1 ns later, registered 1 ns after the rising edge
    task automatic step(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c,
                        input logic v, input string tag);
        int e;
        @(negedge clk);
        x = a; y = b; z = c; in_valid = v;
        e = model(a, b, c);
        #1;
        check("R9 comb valid", int'(c_vld), int'(v));
        if (v) check({tag, " R9 comb"}, int'($signed(c_res)), e);
        if (v) held = e;
        @(posedge clk);
        #1;
        check({tag, " R6 valid"}, int'(r_vld), int'(v));
        check(tag, int'($signed(r_res)), held);
    endtask

    initial begin
        #(2 * HALF * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset valid", int'(r_vld), 0);
        check("R8 reset result", int'(r_res), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1: x alone
        for (int i = 0; i < 32; i++) step(5'(i), 5'd0, 5'd0, 1'b1, "R1 x align");
        // R2: y alone
        for (int i = 0; i < 32; i++) step(5'd0, 5'(i), 5'd0, 1'b1, "R2 y align");
        // R3: z alone
        for (int i = 0; i < 32; i++) step(5'd0, 5'd0, 5'(i), 1'b1, "R3 z align");

        // R5: range ends with explicit bit patterns
        step(5'b10000, 5'b10000, 5'b00000, 1'b1, "R5 min");
        check("R5 min bits", int'(r_res), int'(11'b11111010000));
        step(5'b01111, 5'b01111, 5'b11111, 1'b1, "R5 max");
        check("R5 max bits", int'(r_res), int'(11'b01000011101));

        // R7: idle cycles with changing inputs keep the last result
        step(5'd3, 5'd5, 5'd7, 1'b1, "R7 load");
        step(5'd31, 5'd16, 5'd31, 1'b0, "R7 hold");
        step(5'd16, 5'd1, 5'd0, 1'b0, "R7 hold");

        // R6: single strobe then idle
        step(5'd9, 5'd20, 5'd2, 1'b1, "R6 strobe");
        step(5'd9, 5'd20, 5'd2, 1'b0, "R6 drop");

        // R4: exhaustive sweep with periodic idle gaps
        for (int i = 0; i < 32768; i++) begin
            step(5'(i), 5'(i >> 5), 5'(i >> 10), 1'b1, "R4 sweep");
            if (i % 997 == 0) step(5'(i + 3), 5'(i + 7), 5'(i + 11), 1'b0, "R7 gap");
        end

        // R8: reset during traffic
        @(negedge clk);
        x = 5'd15; y = 5'd15; z = 5'd31; in_valid = 1'b1; rst = 1'b1;
        @(posedge clk);
        #1;
        check("R8 mid valid", int'(r_vld), 0);
        check("R8 mid result", int'(r_res), 0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        held = 0;
        step(5'd1, 5'd1, 5'd1, 1'b1, "R4 after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule